// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This unit applies a chaining mode of operation around an external 64-bit block cipher engine. It handles electronic codebook, cipher block chaining, output feedback and cipher feedback. Cipher feedback takes segments of 8, 16, 32 or 64 bits. The unit holds the chaining register, which an initialization value seeds. It forms the block sent to the engine, combines the engine result with the data, and updates the chaining register, all without software help.

Configuration comes in on plain inputs: mode, segment size, direction, a value to load into the chaining register, and an interrupt enable. Software, or an upstream block, loads the initialization value and then presents a data word on a valid/ready input. Accepting that word starts processing. The controller raises a request to the engine and holds it until the engine acknowledges. It then presents the result on a valid/ready output and raises a data-ready flag. When enabled, the flag drives an interrupt line.

Top module: `cipher_chain_ctrl`

## Requirements
- R1: With `cfg_mode`=0 (codebook), the engine receives the input word unchanged and runs in the direction given by `cfg_decrypt` (1 = decrypt). The output is the engine result. The chaining register has no effect.
- R2: With `cfg_mode`=1 (block chaining) and encrypt, the engine receives input XOR chaining register. The output is the engine result, and the chaining register takes that result.
- R3: With `cfg_mode`=1 and decrypt, the engine decrypts the input word. The output is the engine result XOR chaining register, and the chaining register takes the input word.
- R4: With `cfg_mode`=2 (output feedback), in either direction, the engine encrypts the chaining register. The output is the engine result XOR the input word, and the chaining register takes the engine result.
- R5: With `cfg_mode`=3 (cipher feedback), the engine encrypts the chaining register in either direction. The segment width is s = 8, 16, 32 or 64 for `cfg_seg` = 0, 1, 2 or 3. The low s bits of the output are the top s bits of the engine result XOR the low s input bits. The output bits above s are zero.
- R6: In cipher feedback, the chaining register shifts left by s bits and takes the ciphertext segment into its low bits. The ciphertext segment is the output when encrypting and the low s input bits when decrypting.
- R7: `iv_load` writes `iv_value` into the chaining register in any cycle where no engine request is pending. While a request is pending, `iv_load` is ignored.
- R8: `in_ready` is high when the unit is idle, or when the pending output is taken in that same cycle. `eng_req` holds until `eng_ack`. `out_valid` and `out_data` hold until `out_ready`.
- R9: `data_ready` rises in the cycle after the engine result is captured. It clears after the output is read or a new input is accepted. `irq` equals `data_ready` AND `irq_en`, registered in the same cycle as `data_ready`.
- R10: Mode, segment size and direction are captured when the input word is accepted. Later changes to the configuration inputs do not affect the block in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Chaining mode: 0 codebook, 1 block chaining, 2 output feedback, 3 cipher feedback |
| cfg_seg | input | 2 | Cipher feedback segment code: 0..3 select 8, 16, 32, 64 bits |
| cfg_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| iv_load | input | 1 | Load the chaining register from `iv_value` |
| iv_value | input | 64 | Initialization value |
| irq_en | input | 1 | Interrupt enable |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 64 | Input word (low s bits used in cipher feedback) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with `out_valid` |
| out_data | output | 64 | Result word |
| eng_req | output | 1 | Request to the cipher engine |
| eng_decrypt | output | 1 | Engine direction, 1 = decrypt |
| eng_block | output | 64 | Block presented to the engine |
| eng_ack | input | 1 | Engine result valid, one cycle |
| eng_result | input | 64 | Engine result |
| data_ready | output | 1 | Result available flag |
| irq | output | 1 | Interrupt |

## Verification
Two things can fall in the same cycle: the pending result is read, and the next input word is accepted. The chaining register must already hold the updated feedback value at that point. The bench holds `out_ready` low while a second word waits on `in_valid`, then raises it. It counts the cycle in which both handshakes occur, and the scoreboard compares the second word's chained result against the model. The same sequence also shows that `data_ready` clears and that the interrupt follows the enable.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [1:0] {
    MODE_CODEBOOK = 2'd0,
    MODE_BLKCHAIN = 2'd1,
    MODE_OUTFB    = 2'd2,
    MODE_CIPHFB   = 2'd3
  } chain_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } chain_state_e;

  // segment width in bits for a segment code, block width W
  function automatic int unsigned seg_bits(input logic [1:0] code, input int unsigned w);
    return w >> (3 - code);
  endfunction
endpackage

// File: rtl/chain_pre.sv
module chain_pre
  import chain_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input  chain_mode_e      mode,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  output logic [BLK_W-1:0] blk,
  output logic             dir_dec
);
  always_comb begin
    blk     = data;
    dir_dec = 1'b0;
    unique case (mode)
      MODE_CODEBOOK: begin
        blk     = data;
        dir_dec = decrypt;
      end
      MODE_BLKCHAIN: begin
        blk     = decrypt ? data : (data ^ chain);
        dir_dec = decrypt;
      end
      default: begin
        // both feedback modes run the engine forward on the chain
        blk     = chain;
        dir_dec = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/chain_post.sv
module chain_post
  import chain_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input  chain_mode_e      mode,
  input  logic             decrypt,
  input  logic [1:0]       seg,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] out_word,
  output logic [BLK_W-1:0] chain_nxt
);
  localparam logic [BLK_W-1:0] ONES = {BLK_W{1'b1}};

  int unsigned      s;
  logic [BLK_W-1:0] mask;
  logic [BLK_W-1:0] keystream;
  logic [BLK_W-1:0] seg_out;
  logic [BLK_W-1:0] seg_ct;

  always_comb begin
    s         = seg_bits(seg, BLK_W);
    mask      = ONES >> (BLK_W - s);
    keystream = result >> (BLK_W - s);
    seg_out   = (keystream ^ data) & mask;
    seg_ct    = decrypt ? (data & mask) : seg_out;
  end

  always_comb begin
    out_word  = result;
    chain_nxt = chain;
    unique case (mode)
      MODE_CODEBOOK: begin
        out_word  = result;
        chain_nxt = chain;
      end
      MODE_BLKCHAIN: begin
        out_word  = decrypt ? (result ^ chain) : result;
        chain_nxt = decrypt ? data : result;
      end
      MODE_OUTFB: begin
        out_word  = result ^ data;
        chain_nxt = result;
      end
      default: begin
        out_word  = seg_out;
        chain_nxt = (s == BLK_W) ? seg_ct : ((chain << s) | seg_ct);
      end
    endcase
  end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic eng_ack,
  input  logic irq_en,
  output logic in_ready,
  output logic accept,
  output logic capture,
  output logic eng_req,
  output logic out_valid,
  output logic data_ready,
  output logic irq
);
  chain_state_e st, st_nxt;
  logic         dr_nxt;

  assign in_ready  = (st == ST_IDLE) || ((st == ST_HOLD) && out_ready);
  assign accept    = in_valid && in_ready;
  assign capture   = (st == ST_BUSY) && eng_ack;
  assign eng_req   = (st == ST_BUSY);
  assign out_valid = (st == ST_HOLD);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (accept) st_nxt = ST_BUSY;
      ST_BUSY: if (eng_ack) st_nxt = ST_HOLD;
      ST_HOLD: if (out_ready) st_nxt = accept ? ST_BUSY : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    dr_nxt = data_ready;
    if (accept || (out_valid && out_ready)) dr_nxt = 1'b0;
    if (capture) dr_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      data_ready <= 1'b0;
      irq        <= 1'b0;
    end else begin
      st         <= st_nxt;
      data_ready <= dr_nxt;
      irq        <= dr_nxt && irq_en;
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_ack |=> eng_req);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);
  p_ready_excl_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !eng_req);
  p_dr_clear_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !data_ready);
  p_dr_set_r9: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_ack |=> data_ready && out_valid);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> data_ready);
endmodule

// File: rtl/cipher_chain_ctrl.sv
module cipher_chain_ctrl
  import chain_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_seg,
  input  logic             cfg_decrypt,
  input  logic             iv_load,
  input  logic [BLK_W-1:0] iv_value,
  input  logic             irq_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic             eng_req,
  output logic             eng_decrypt,
  output logic [BLK_W-1:0] eng_block,
  input  logic             eng_ack,
  input  logic [BLK_W-1:0] eng_result,
  output logic             data_ready,
  output logic             irq
);
  chain_mode_e      lat_mode;
  logic [1:0]       lat_seg;
  logic             lat_dec;
  logic [BLK_W-1:0] lat_data;
  logic [BLK_W-1:0] chain_q;
  logic [BLK_W-1:0] post_out;
  logic [BLK_W-1:0] post_chain;
  logic             accept;
  logic             capture;

  chain_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .eng_ack    (eng_ack),
    .irq_en     (irq_en),
    .in_ready   (in_ready),
    .accept     (accept),
    .capture    (capture),
    .eng_req    (eng_req),
    .out_valid  (out_valid),
    .data_ready (data_ready),
    .irq        (irq)
  );

  chain_pre #(.BLK_W(BLK_W)) u_pre (
    .mode    (lat_mode),
    .decrypt (lat_dec),
    .data    (lat_data),
    .chain   (chain_q),
    .blk     (eng_block),
    .dir_dec (eng_decrypt)
  );

  chain_post #(.BLK_W(BLK_W)) u_post (
    .mode      (lat_mode),
    .decrypt   (lat_dec),
    .seg       (lat_seg),
    .data      (lat_data),
    .chain     (chain_q),
    .result    (eng_result),
    .out_word  (post_out),
    .chain_nxt (post_chain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_mode <= MODE_CODEBOOK;
      lat_seg  <= 2'd0;
      lat_dec  <= 1'b0;
      lat_data <= '0;
      chain_q  <= '0;
      out_data <= '0;
    end else begin
      if (accept) begin
        lat_mode <= chain_mode_e'(cfg_mode);
        lat_seg  <= cfg_seg;
        lat_dec  <= cfg_decrypt;
        lat_data <= in_data;
      end
      if (capture) begin
        out_data <= post_out;
        chain_q  <= post_chain;
      end else if (iv_load && !eng_req) begin
        chain_q  <= iv_value;
      end
    end
  end

  p_stream_dir_r4: assert property (@(posedge clk) disable iff (rst)
    eng_req && (lat_mode == MODE_OUTFB || lat_mode == MODE_CIPHFB) |-> !eng_decrypt);
  p_seg8_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && lat_mode == MODE_CIPHFB && lat_seg == 2'd0 |-> out_data[BLK_W-1:8] == '0);
  p_iv_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_ack |=> $stable(chain_q));
  p_block_stable_r10: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_ack |=> $stable(eng_block) && $stable(eng_decrypt));
  p_out_stable_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: tb/tb_cipher_chain_ctrl.sv
module tb_cipher_chain_ctrl;
  localparam logic [63:0] KEY = 64'h5A3C_96E1_0F87_D24B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_seg = '0;
  logic        cfg_decrypt = 1'b0;
  logic        iv_load = 1'b0;
  logic [63:0] iv_value = '0;
  logic        irq_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        eng_req, eng_decrypt;
  logic [63:0] eng_block;
  logic        eng_ack = 1'b0;
  logic [63:0] eng_result = '0;
  logic        data_ready, irq;

  int checks = 0;
  int errors = 0;
  int both_cycles = 0;
  bit done = 0;
  logic [63:0] fb_m = '0;
  logic [63:0] exp_q[$];
  int          tag_q[$];

  always #2 clk = ~clk;

  cipher_chain_ctrl dut (.*);

  function automatic logic [63:0] enc_f(input logic [63:0] x);
    return {x[50:0], x[63:51]} ^ KEY;
  endfunction
  function automatic logic [63:0] dec_f(input logic [63:0] y);
    logic [63:0] z;
    z = y ^ KEY;
    return {z[12:0], z[63:13]};
  endfunction

  // engine model: fixed latency, one-cycle acknowledge
  logic        pend = 1'b0;
  int          lat = 0;
  logic [63:0] blk_q;
  logic        dir_q;
  always @(posedge clk) begin
    eng_ack <= 1'b0;
    if (eng_req && !eng_ack && !pend) begin
      pend <= 1'b1; lat <= 2; blk_q <= eng_block; dir_q <= eng_decrypt;
    end else if (pend) begin
      if (lat == 0) begin
        eng_ack    <= 1'b1;
        eng_result <= dir_q ? dec_f(blk_q) : enc_f(blk_q);
        pend       <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model of the chaining requirements
  function automatic logic [63:0] model(input logic [1:0] m, input logic [1:0] sc,
                                        input logic d, input logic [63:0] x);
    logic [63:0] r, o, ks, mask, ct;
    int s;
    case (m)
      2'd0: o = d ? dec_f(x) : enc_f(x);                       // R1
      2'd1: if (!d) begin o = enc_f(x ^ fb_m); fb_m = o; end   // R2
            else begin o = dec_f(x) ^ fb_m; fb_m = x; end      // R3
      2'd2: begin r = enc_f(fb_m); o = r ^ x; fb_m = r; end    // R4
      default: begin                                           // R5 R6
        s = 8 << sc;
        r = enc_f(fb_m);
        mask = {64{1'b1}} >> (64 - s);
        ks = r >> (64 - s);
        o = (ks ^ x) & mask;
        ct = d ? (x & mask) : o;
        fb_m = (s == 64) ? ct : ((fb_m << s) | ct);
      end
    endcase
    return o;
  endfunction

  task automatic send(input logic [1:0] m, input logic [1:0] sc, input logic d,
                      input logic [63:0] x, input int tag);
    @(negedge clk);
    cfg_mode = m; cfg_seg = sc; cfg_decrypt = d; in_data = x; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(m, sc, d, x));
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R10: disturb configuration while the block is in flight
    cfg_mode = ~m; cfg_seg = ~sc; cfg_decrypt = ~d; in_data = ~x;
  endtask

  task automatic load_iv(input logic [63:0] v);
    @(negedge clk);
    while (eng_req) @(negedge clk);
    iv_value = v; iv_load = 1'b1;
    @(negedge clk);
    iv_load = 1'b0;
    fb_m = v;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || in_valid) && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (in_valid && in_ready) both_cycles++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected output actual=%h expected=none", out_data);
      end else begin
        logic [63:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk($sformatf("R%0d data", t), out_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R8 R9
    chk("R8 reset in_ready", in_ready, 1'b1);
    chk("R8 reset out_valid", out_valid, 1'b0);
    chk("R8 reset eng_req", eng_req, 1'b0);
    chk("R9 reset data_ready", data_ready, 1'b0);
    chk("R9 reset irq", irq, 1'b0);

    // R1: codebook ignores the chaining register
    load_iv(64'hFFFF_0000_DEAD_BEEF);
    send(2'd0, 2'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 1);
    send(2'd0, 2'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 1);
    send(2'd0, 2'd0, 1'b1, 64'hCAFE_F00D_1234_5678, 1);
    drain();

    // R2 then R3
    load_iv(64'h1111_2222_3333_4444);
    send(2'd1, 2'd0, 1'b0, 64'hA5A5_A5A5_5A5A_5A5A, 2);
    send(2'd1, 2'd0, 1'b0, 64'hA5A5_A5A5_5A5A_5A5A, 2);
    send(2'd1, 2'd0, 1'b0, 64'h0000_0000_0000_0001, 2);
    load_iv(64'h9999_8888_7777_6666);
    send(2'd1, 2'd0, 1'b1, 64'h0F0F_1E1E_2D2D_3C3C, 3);
    send(2'd1, 2'd0, 1'b1, 64'h7777_0000_3333_ABCD, 3);
    drain();

    // R4 in both directions
    load_iv(64'h0BAD_CAFE_0BAD_CAFE);
    send(2'd2, 2'd0, 1'b0, 64'h1357_9BDF_0246_8ACE, 4);
    send(2'd2, 2'd0, 1'b1, 64'hFEDC_BA98_7654_3210, 4);
    send(2'd2, 2'd0, 1'b0, 64'h0, 4);
    drain();

    // R5 R6: every segment size, both directions
    for (int sc = 0; sc < 4; sc++) begin
      load_iv(64'h0102_0304_0506_0708 ^ {32'(sc), 32'(sc)});
      send(2'd3, sc[1:0], 1'b0, 64'hFFEE_DDCC_BBAA_9988, 5);
      send(2'd3, sc[1:0], 1'b0, 64'h1122_3344_5566_7788, 6);
      send(2'd3, sc[1:0], 1'b1, 64'h8765_4321_0FED_CBA9, 6);
      send(2'd3, sc[1:0], 1'b1, 64'h00FF_00FF_00FF_00FF, 6);
      drain();
    end

    // R7: load during a pending request is ignored
    load_iv(64'h2468_ACE0_1357_9BDF);
    send(2'd1, 2'd0, 1'b0, 64'h5555_AAAA_5555_AAAA, 7);
    chk("R7 request pending", eng_req, 1'b1);
    iv_value = 64'hDEAD_DEAD_DEAD_DEAD; iv_load = 1'b1;
    @(negedge clk);
    iv_load = 1'b0;
    send(2'd1, 2'd0, 1'b0, 64'h5555_AAAA_5555_AAAA, 7);
    drain();

    // R9 and the output/input coincidence, R8
    irq_en = 1'b1; out_ready = 1'b0;
    send(2'd1, 2'd0, 1'b0, 64'h3C3C_3C3C_C3C3_C3C3, 8);
    while (!out_valid) @(negedge clk);
    @(negedge clk);
    chk("R9 data_ready set", data_ready, 1'b1);
    chk("R9 irq enabled", irq, 1'b1);
    chk("R8 held in_ready", in_ready, 1'b0);
    irq_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 irq masked", irq, 1'b0);
    chk("R9 data_ready kept", data_ready, 1'b1);
    fork
      send(2'd1, 2'd0, 1'b0, 64'h9696_6969_9696_6969, 8);
    join_none
    @(negedge clk); @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 data_ready cleared", data_ready, 1'b0);
    drain();
    chk("R8 read and accept same cycle", (both_cycles >= 1), 1'b1);
    chk("R8 scoreboard empty", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule